// File: doc/BRIEF.md
# Serial PCM Channel Port with Control Registers

This block is the digital serial side of one telephony filter/codec channel on a 2.048 MHz time-division bus. An active-low frame/channel strobe, together with a three-level address input, opens a slot of eight bit-clock cycles. In a PCM slot the port shifts one 8-bit word in from the serial data input and shifts one 8-bit word out onto the serial data output. In the same slot it shifts an 8-bit word from the serial control input into control register A or control register B. The address level picks the register.

When the address is at its low level, the strobe opens a static slot instead. No PCM moves, and the control input is treated as a level that is tied high or low. A constant high level loads all ones into both registers, and a constant low level loads all zeros. Register B feeds the general-purpose control outputs. Register A is exported whole for the powerdown, gain, loopback and test controls of the analog side, which is outside this block.

The controller is a four-state machine:
- `ST_IDLE` moves to `ST_SLOT_A` when the strobe is seen with the mid level.
- `ST_IDLE` moves to `ST_SLOT_B` when the strobe is seen with the high level.
- `ST_IDLE` moves to `ST_STATIC` when the strobe is seen with the low level.
- Each slot state returns to `ST_IDLE` on its eighth bit edge ("finish").
- Each slot state also returns to `ST_IDLE` at any bit edge where the address no longer matches the slot's level ("abort").
- The unused code 2'b11 leaves `ST_IDLE` in place.

Top module: `pcm_chan_port`

## Requirements
- R1: A synchronous active-high reset clears ctl_a, ctl_b, rx_word and rx_valid, drops dat_oe and returns the controller to idle, even in the middle of a slot.
- R2: In idle, a rising edge that samples frame_n low with addr_lvl 2'b01 (mid) or 2'b10 (high) starts a PCM slot. dat_oe is high from the next cycle for exactly 8 cycles.
- R3: tx_word is captured at the start edge and sent most significant bit first on dat_out, one bit per cycle. Bit 7 is on the line in the first slot cycle.
- R4: dat_in is sampled at the 8 rising edges after the start edge, most significant bit first. After the eighth, rx_word holds the word and rx_valid is high for one cycle.
- R5: ctl_in is sampled at the same 8 edges. At the eighth edge the word goes to ctl_a for level 2'b01 or to ctl_b for level 2'b10, in the same cycle rx_word updates.
- R6: A strobe with addr_lvl 2'b00 (low) starts a static slot without driving dat_oe. If ctl_in is 1 at all 8 edges, both registers become 8'hFF. If it is 0 at all 8, both become 8'h00. Otherwise neither register changes.
- R7: If addr_lvl differs from the slot's starting level at any of its 8 bit edges, the slot ends at that edge. dat_oe is released, no register changes and rx_valid stays low.
- R8: frame_n is ignored while a slot is in progress, including its eighth edge. A strobe with addr_lvl 2'b11 starts nothing.
- R9: gpo[i] equals bit i of ctl_b for each of the NUM_GPO outputs (bits 5..0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame/channel strobe, active low |
| addr_lvl | input | 2 | Three-level address: 00 low, 01 mid, 10 high, 11 unused |
| dat_in | input | 1 | Serial PCM receive data |
| ctl_in | input | 1 | Serial control word or static level |
| tx_word | input | 8 | Parallel PCM word to transmit |
| dat_out | output | 1 | Serial PCM transmit data, valid while dat_oe is high |
| dat_oe | output | 1 | Output enable for the shared three-state line |
| rx_word | output | 8 | Last received PCM word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is new |
| ctl_a | output | 8 | Control register A |
| ctl_b | output | 8 | Control register B |
| gpo | output | 6 | General-purpose control outputs from ctl_b |

## Verification
At the eighth bit edge of a PCM slot, three things happen in one clock cycle:
- the received word is committed,
- a control register loads,
- the output enable is released.

Every PCM slot provokes this. The bench samples on the falling edge after that clock and judges rx_word, rx_valid, ctl_a or ctl_b, gpo and dat_oe together against its own model. A strobe held low through that same final edge tests whether a new slot wrongly starts while the old one finishes. Random aborts, placed on every bit edge including the last, test that cancellation wins over completion when both fall on one edge.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_A    = 2'b01,
        LVL_B    = 2'b10,
        LVL_NONE = 2'b11
    } addr_lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SLOT_A = 2'b01,
        ST_SLOT_B = 2'b10,
        ST_STATIC = 2'b11
    } slot_state_e;

endpackage

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic [1:0]  addr_lvl,
    output slot_state_e state,
    output logic        start_pcm,
    output logic        bit_edge,
    output logic        last_bit,
    output logic        pcm_active
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

    slot_state_e      nxt;
    logic [CNT_W-1:0] cnt;
    logic             lvl_ok;
    addr_lvl_e        lvl;

    assign lvl = addr_lvl_e'(addr_lvl);

    // does the address still match the level that opened the slot
    always_comb begin
        unique case (state)
            ST_SLOT_A: lvl_ok = (lvl == LVL_A);
            ST_SLOT_B: lvl_ok = (lvl == LVL_B);
            ST_STATIC: lvl_ok = (lvl == LVL_OFF);
            default:   lvl_ok = 1'b0;
        endcase
    end

    // next state: start, finish, abort
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!frame_n) begin
                    unique case (lvl)
                        LVL_A:    nxt = ST_SLOT_A;
                        LVL_B:    nxt = ST_SLOT_B;
                        LVL_OFF:  nxt = ST_STATIC;
                        LVL_NONE: nxt = ST_IDLE;
                    endcase
                end
            end
            ST_SLOT_A, ST_SLOT_B, ST_STATIC: begin
                if (!lvl_ok || cnt == LAST_CNT) begin
                    nxt = ST_IDLE;
                end
            end
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state != ST_IDLE && nxt != ST_IDLE) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // decoded outputs
    always_comb begin
        start_pcm  = 1'b0;
        pcm_active = 1'b0;
        bit_edge   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start_pcm = (nxt == ST_SLOT_A) || (nxt == ST_SLOT_B);
            end
            ST_SLOT_A, ST_SLOT_B: begin
                pcm_active = 1'b1;
                bit_edge   = lvl_ok;
            end
            ST_STATIC: begin
                bit_edge = lvl_ok;
            end
        endcase
        last_bit = bit_edge && (cnt == LAST_CNT);
    end

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] par,
    input  logic              oe,
    output logic              ser
);
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= par;
        end else if (shift) begin
            sh <= {sh[WORD_W-2:0], 1'b0};
        end
    end

    assign ser = oe & sh[WORD_W-1];

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              din,
    output logic [WORD_W-1:0] word_nxt
);
    logic [WORD_W-2:0] sh;

    assign word_nxt = {sh, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (shift) begin
            sh <= word_nxt[WORD_W-2:0];
        end
    end

endmodule

// File: rtl/pcm_ctl_bank.sv
module pcm_ctl_bank #(
    parameter int WORD_W  = 8,
    parameter int NUM_GPO = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_a,
    input  logic               load_b,
    input  logic               load_static,
    input  logic [WORD_W-1:0]  word,
    output logic [WORD_W-1:0]  ctl_a,
    output logic [WORD_W-1:0]  ctl_b,
    output logic [NUM_GPO-1:0] gpo
);
    logic all_hi;
    logic all_lo;

    assign all_hi = (word == '1);
    assign all_lo = (word == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a <= '0;
            ctl_b <= '0;
        end else if (load_static) begin
            if (all_hi) begin
                ctl_a <= '1;
                ctl_b <= '1;
            end else if (all_lo) begin
                ctl_a <= '0;
                ctl_b <= '0;
            end
        end else begin
            if (load_a) ctl_a <= word;
            if (load_b) ctl_b <= word;
        end
    end

    for (genvar gi = 0; gi < NUM_GPO; gi++) begin : g_gpo
        assign gpo[gi] = ctl_b[gi];
    end

endmodule

// File: rtl/pcm_chan_port.sv
module pcm_chan_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int NUM_GPO = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_n,
    input  logic [1:0]         addr_lvl,
    input  logic               dat_in,
    input  logic               ctl_in,
    input  logic [WORD_W-1:0]  tx_word,
    output logic               dat_out,
    output logic               dat_oe,
    output logic [WORD_W-1:0]  rx_word,
    output logic               rx_valid,
    output logic [WORD_W-1:0]  ctl_a,
    output logic [WORD_W-1:0]  ctl_b,
    output logic [NUM_GPO-1:0] gpo
);
    slot_state_e       state;
    logic              start_pcm;
    logic              bit_edge;
    logic              last_bit;
    logic              pcm_active;
    logic [WORD_W-1:0] rx_nxt;
    logic [WORD_W-1:0] ctl_nxt;
    logic              pcm_done;

    pcm_slot_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .addr_lvl  (addr_lvl),
        .state     (state),
        .start_pcm (start_pcm),
        .bit_edge  (bit_edge),
        .last_bit  (last_bit),
        .pcm_active(pcm_active)
    );

    assign dat_oe = pcm_active;

    pcm_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .load (start_pcm),
        .shift(bit_edge),
        .par  (tx_word),
        .oe   (pcm_active),
        .ser  (dat_out)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_rx_dat (
        .clk     (clk),
        .rst     (rst),
        .shift   (bit_edge),
        .din     (dat_in),
        .word_nxt(rx_nxt)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_rx_ctl (
        .clk     (clk),
        .rst     (rst),
        .shift   (bit_edge),
        .din     (ctl_in),
        .word_nxt(ctl_nxt)
    );

    pcm_ctl_bank #(.WORD_W(WORD_W), .NUM_GPO(NUM_GPO)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load_a     (last_bit && state == ST_SLOT_A),
        .load_b     (last_bit && state == ST_SLOT_B),
        .load_static(last_bit && state == ST_STATIC),
        .word       (ctl_nxt),
        .ctl_a      (ctl_a),
        .ctl_b      (ctl_b),
        .gpo        (gpo)
    );

    assign pcm_done = last_bit && pcm_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= pcm_done;
            if (pcm_done) begin
                rx_word <= rx_nxt;
            end
        end
    end

endmodule

// File: rtl/pcm_chan_port_chk.sv
module pcm_chan_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_n,
    input logic              dat_oe,
    input logic              rx_valid,
    input logic [WORD_W-1:0] ctl_a,
    input logic [WORD_W-1:0] ctl_b
);
    logic [7:0] oe_run;

    always_ff @(posedge clk) begin
        if (rst) oe_run <= '0;
        else     oe_run <= dat_oe ? oe_run + 1'b1 : 8'd0;
    end

    // R2
    oe_len_chk: assert property (@(posedge clk) disable iff (rst)
        oe_run <= 8'(WORD_W));

    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe) |-> $past(!frame_n));

    // R4
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4
    rx_full_slot_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (oe_run == 8'(WORD_W) && !dat_oe));

    // R6
    a_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_a) |-> (rx_valid || ctl_a == '1 || ctl_a == '0));

    // R6
    b_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_b) |-> (rx_valid || ctl_b == '1 || ctl_b == '0));

endmodule

bind pcm_chan_port pcm_chan_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .frame_n (frame_n),
    .dat_oe  (dat_oe),
    .rx_valid(rx_valid),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b)
);

// File: tb/sim_pcm_chan_port.sv
module sim_pcm_chan_port;
    localparam int W = 8;
    localparam int G = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         frame_n;
    logic [1:0]   addr_lvl;
    logic         dat_in;
    logic         ctl_in;
    logic [W-1:0] tx_word;
    logic         dat_out;
    logic         dat_oe;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    logic [W-1:0] ctl_a;
    logic [W-1:0] ctl_b;
    logic [G-1:0] gpo;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [W-1:0] e_a  = '0;
    logic [W-1:0] e_b  = '0;
    logic [W-1:0] e_rx = '0;

    always #5 clk = ~clk;

    pcm_chan_port #(.WORD_W(W), .NUM_GPO(G)) u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .addr_lvl(addr_lvl),
        .dat_in(dat_in), .ctl_in(ctl_in), .tx_word(tx_word),
        .dat_out(dat_out), .dat_oe(dat_oe), .rx_word(rx_word),
        .rx_valid(rx_valid), .ctl_a(ctl_a), .ctl_b(ctl_b), .gpo(gpo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] static_a(input logic [W-1:0] cur, input logic [W-1:0] w);
        if (w == '1) return '1;
        if (w == '0) return '0;
        return cur;
    endfunction

    task automatic check_regs(input string req);
        chk({req, " ctl_a"}, 32'(ctl_a), 32'(e_a));
        chk({req, " ctl_b"}, 32'(ctl_b), 32'(e_b));
        chk("R9 gpo", 32'(gpo), 32'(e_b[G-1:0]));
    endtask

    // one slot: strobe at N0, bits driven at N1..N8, results checked at N9
    task automatic run_slot(input logic [1:0] lvl, input logic [W-1:0] txw,
                            input logic [W-1:0] rxw, input logic [W-1:0] ctw,
                            input int abort_k, input bit hold);
        bit pcm_en  = (lvl == 2'b01) || (lvl == 2'b10);
        bit is_slot = (lvl != 2'b11);
        bit aborted = 0;
        bit ab_chk  = 0;
        @(negedge clk);
        frame_n = 1'b0; addr_lvl = lvl; tx_word = txw;
        for (int k = 1; k <= W; k++) begin
            @(negedge clk);
            if (ab_chk) begin
                chk("R7 oe after abort", 32'(dat_oe), 0);
                ab_chk = 0;
            end
            if (!aborted) begin
                chk(pcm_en ? "R2 oe in slot" : "R8 no oe", 32'(dat_oe), 32'(pcm_en));
                if (pcm_en) chk("R3 tx bit", 32'(dat_out), 32'(txw[W-k]));
            end
            frame_n = (hold && !aborted) ? 1'b0 : 1'b1;
            dat_in  = rxw[W-k];
            ctl_in  = ctw[W-k];
            if (k == abort_k && is_slot && !aborted) begin
                addr_lvl = (lvl == 2'b00) ? 2'b01 : 2'b00;
                frame_n  = 1'b1;
                aborted  = 1;
                ab_chk   = 1;
            end
        end
        @(negedge clk);
        frame_n = 1'b1;
        if (!aborted && pcm_en) begin
            e_rx = rxw;
            if (lvl == 2'b01) e_a = ctw; else e_b = ctw;
        end else if (!aborted && lvl == 2'b00) begin
            e_a = static_a(e_a, ctw);
            e_b = static_a(e_b, ctw);
        end
        chk("R2 oe released", 32'(dat_oe), 0);
        chk(aborted ? "R7 no rx_valid" : "R4 rx_valid", 32'(rx_valid), 32'(pcm_en && !aborted));
        chk("R4 rx_word", 32'(rx_word), 32'(e_rx));
        check_regs(aborted ? "R7" : (lvl == 2'b00 ? "R6" : "R5"));
        addr_lvl = 2'b11;
        @(negedge clk);
        chk("R4 rx_valid one cycle", 32'(rx_valid), 0);
        chk("R8 idle oe", 32'(dat_oe), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0DEC5));
        rst = 1'b1; frame_n = 1'b1; addr_lvl = 2'b11;
        dat_in = 1'b0; ctl_in = 1'b0; tx_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset oe", 32'(dat_oe), 0);
        chk("R1 reset rx_valid", 32'(rx_valid), 0);
        chk("R1 reset rx_word", 32'(rx_word), 0);
        check_regs("R1");

        // directed cases
        run_slot(2'b01, 8'hA5, 8'h3C, 8'h81, 0, 0);   // R5 load A
        run_slot(2'b10, 8'h5A, 8'hC3, 8'h7E, 0, 0);   // R5 load B
        run_slot(2'b00, 8'h00, 8'h00, 8'hFF, 0, 0);   // R6 static high
        run_slot(2'b00, 8'h00, 8'h00, 8'h00, 0, 0);   // R6 static low
        run_slot(2'b00, 8'h00, 8'h00, 8'h7F, 0, 0);   // R6 toggling ignored
        run_slot(2'b10, 8'h96, 8'h69, 8'h2D, 0, 1);   // R8 strobe held
        run_slot(2'b11, 8'hFF, 8'hAA, 8'h55, 0, 1);   // R8 unused level
        run_slot(2'b01, 8'h0F, 8'hF0, 8'h11, W, 0);   // R7 abort last edge
        run_slot(2'b10, 8'hF0, 8'h0F, 8'h22, 1, 0);   // R7 abort first edge
        run_slot(2'b00, 8'h00, 8'h00, 8'hFF, 4, 0);   // R7 static abort

        // random cases
        for (int i = 0; i < 80; i++) begin
            logic [1:0]   lv = 2'($urandom_range(0, 3));
            logic [W-1:0] cw = W'($urandom);
            int           ab = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, W)) : 0;
            if (lv == 2'b00 && $urandom_range(0, 1) == 1) cw = $urandom_range(0, 1) ? '1 : '0;
            run_slot(lv, W'($urandom), W'($urandom), cw, ab, bit'($urandom_range(0, 1)));
        end

        // R1 reset in mid-slot
        @(negedge clk);
        frame_n = 1'b0; addr_lvl = 2'b10; tx_word = 8'hFF;
        @(negedge clk);
        frame_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; addr_lvl = 2'b11;
        e_a = '0; e_b = '0; e_rx = '0;
        @(negedge clk);
        chk("R1 mid-slot oe", 32'(dat_oe), 0);
        chk("R1 mid-slot rx_word", 32'(rx_word), 0);
        check_regs("R1");
        run_slot(2'b01, 8'hC9, 8'h9C, 8'h44, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule